// File: doc/BRIEF.md
# Serial Audio Link Interrupt Controller

This block collects the interrupt sources of a controller for an AC'97-style serial audio link and presents them to software as raw status, masked status and one combined interrupt line. The framing logic feeds it per-frame strobes and bits it has already decoded from the incoming slots: the ready flag of the tag slot and the received GPIO slot word. It also watches the receive FIFO empty flags and push strobes, the transmit FIFO and shifter idle flags, the outgoing command slot traffic and the raw serial data input.

There are five kinds of source, and each one clears in its own way. The receive timeout exists once per receive channel. It is a frame-counted watchdog that drops when its FIFO drains. Transmit complete is a level that follows the transmit path. Codec ready and link wake-up are sticky bits that are cleared by writing one to an end-of-interrupt register. The GPIO-change bit is cleared when software reads the latched slot 12 word.

Wake-up is only recognised while the link is believed to be powered down. The block infers this with a two-state machine. `LINK_ACTIVE` moves to `LINK_DOWN` when an outgoing command writes (not reads) the power-down register of the codec with the power-down bit set. `LINK_DOWN` returns to `LINK_ACTIVE` when a warm or cold link reset is requested. Each receive channel runs a three-state machine. `TO_IDLE` holds while the FIFO is empty or the timeout is disabled. It moves to `TO_COUNT` when the FIFO is non-empty and the count is not zero. `TO_COUNT` moves to `TO_FIRED` when the frame count expires. From `TO_COUNT` or `TO_FIRED` the machine returns to `TO_IDLE` when the FIFO empties. `TO_COUNT` also returns to `TO_IDLE` when the count is set to zero.

Top module: `codec_irq_ctrl`

## Requirements
- R1: With receive channel k's FIFO non-empty and its timeout count T (bits [k*TOC_W +: TOC_W] of register 4) not zero, status bit k sets on the edge of the T-th frame strobe after the last push into that FIFO. A push reloads the count to T.
- R2: Receive timeout bit k clears on the first clock edge at which channel k's FIFO is empty.
- R3: A timeout count of 0 keeps bit k clear, including when the count is changed to 0 while counting is in progress.
- R4: Status bit NUM_RX_CH (transmit complete) equals the AND of the transmit-FIFO-empty and shifter-idle inputs, with one cycle of latency.
- R5: Status bit NUM_RX_CH+1 (codec ready) sets when a tag slot arrives with its bit 15 flag high. It stays set until a write to register 1 carries a one in that bit position. Writing zeros has no effect.
- R6: The powered-down state is entered only by an outgoing command that is a write (command read flag low) to codec register 7'h26 with data bit 12 high. It is left on a link reset request. Outside that state, serial input edges set nothing.
- R7: In the powered-down state, a 0-to-1 change on the serial input sets status bit NUM_RX_CH+2 (wake) on the third clock edge after the input rises, because of a two-flop synchroniser and an edge register. The bit is sticky and is cleared by a write of one to that bit of register 1.
- R8: Status bit NUM_RX_CH+3 (GPIO) sets when a received slot 12 word has bit 0 high. Every received slot 12 word is latched. Reading register 5 returns the latched word and clears the bit.
- R9: Register 0 is the read/write mask. Register 2 reads raw status. Register 3 reads raw status AND mask. Register 4 holds the timeout counts. Unused upper read bits are zero, and everything resets to 0.
- R10: The interrupt output is the registered OR of the masked status, one cycle after the masked status changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| frame_strobe | input | 1 | One-cycle pulse per link frame |
| tag_valid | input | 1 | A tag slot was received this cycle |
| tag_ready_bit | input | 1 | Bit 15 of the received tag slot |
| s12_valid | input | 1 | A slot 12 word was received this cycle |
| s12_word | input | S12_W | Received slot 12 word |
| cmd_valid | input | 1 | An outgoing command slot pair is sent this cycle |
| cmd_rd | input | 1 | Outgoing command is a read |
| cmd_addr | input | 7 | Outgoing command register address |
| cmd_data | input | 16 | Outgoing command write data |
| link_reset_req | input | 1 | Warm or cold link reset requested |
| rx_push | input | NUM_RX_CH | Word written into receive FIFO k |
| rx_empty | input | NUM_RX_CH | Receive FIFO k empty |
| tx_empty | input | 1 | Transmit FIFO empty |
| shifter_idle | input | 1 | Parallel-to-serial shifter holds no data |
| sdata_in | input | 1 | Raw serial data input (asynchronous) |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | DATA_W | Register write data |
| rd_en | input | 1 | Register read strobe |
| rd_addr | input | 3 | Register read address |
| rd_data | output | DATA_W | Register read data (combinational) |
| irq_out | output | 1 | Combined interrupt |

## Verification
The bench builds the block with two receive channels and a 3-bit timeout field. With only two channels, one channel can sit disabled while the other fires, which shows that the timeout bits are kept separate. With a 3-bit field, a reload, a mid-count disable and the exact expiry edge each take only a few frames to reach. It uses a 20-bit slot 12 word, so the latched word can be checked whole through the read port. The wake sequence is stepped through edge by edge, so the three-edge synchroniser latency and the rejection of read commands and of writes with the power-down bit clear are each observed at the status register.

// File: rtl/cil_pkg.sv
package cil_pkg;

    typedef enum logic [2:0] {
        RA_MASK = 3'd0,
        RA_EOI  = 3'd1,
        RA_RAW  = 3'd2,
        RA_MSKD = 3'd3,
        RA_TOC  = 3'd4,
        RA_S12  = 3'd5
    } reg_addr_e;

    typedef enum logic {
        LINK_ACTIVE = 1'b0,
        LINK_DOWN   = 1'b1
    } link_state_e;

    typedef enum logic [1:0] {
        TO_IDLE  = 2'd0,
        TO_COUNT = 2'd1,
        TO_FIRED = 2'd2
    } to_state_e;

endpackage

// File: rtl/cil_sticky.sv
module cil_sticky (
    input  logic clk,
    input  logic rst_n,
    input  logic set,
    input  logic clr,
    output logic q
);

    // a set wins over a clear arriving in the same cycle
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    q <= 1'b0;
        else if (set)  q <= 1'b1;
        else if (clr)  q <= 1'b0;
    end

endmodule

// File: rtl/cil_rx_timeout.sv
module cil_rx_timeout
    import cil_pkg::*;
#(
    parameter int TOC_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             frame_strobe,
    input  logic             rx_push,
    input  logic             rx_empty,
    input  logic [TOC_W-1:0] toc,
    output logic             timeout
);

    to_state_e        state, state_n;
    logic [TOC_W-1:0] cnt, cnt_n;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= TO_IDLE;
            cnt   <= '0;
        end else begin
            state <= state_n;
            cnt   <= cnt_n;
        end
    end

    always_comb begin
        state_n = state;
        cnt_n   = cnt;
        unique case (state)
            TO_IDLE: begin
                cnt_n = toc;
                if (!rx_empty && toc != '0) state_n = TO_COUNT;
            end
            TO_COUNT: begin
                if (rx_empty || toc == '0) begin
                    state_n = TO_IDLE;
                end else if (rx_push) begin
                    cnt_n = toc;
                end else if (frame_strobe) begin
                    if (cnt <= TOC_W'(1)) state_n = TO_FIRED;
                    else                  cnt_n   = cnt - TOC_W'(1);
                end
            end
            TO_FIRED: begin
                if (rx_empty) state_n = TO_IDLE;
            end
            default: state_n = TO_IDLE;
        endcase
    end

    always_comb timeout = (state == TO_FIRED);

    assert_rto_drain_R2: assert property (@(posedge clk) disable iff (!rst_n)
        rx_empty |=> !timeout);

    assert_rto_disabled_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (toc == '0 && !timeout) |=> !timeout);

    assert_rto_reload_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (state == TO_COUNT && rx_push && !rx_empty && toc != '0) |=> !timeout);

endmodule

// File: rtl/cil_link_power.sv
module cil_link_power
    import cil_pkg::*;
#(
    parameter logic [6:0] PD_ADDR = 7'h26,
    parameter int         PD_BIT  = 12
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cmd_valid,
    input  logic        cmd_rd,
    input  logic [6:0]  cmd_addr,
    input  logic [15:0] cmd_data,
    input  logic        link_reset_req,
    input  logic        sdata_in,
    output logic        link_down,
    output logic        wake_evt
);

    link_state_e state, state_n;
    logic [2:0]  sd_q;
    logic        rise;
    logic        pd_write;
    logic        unused_cmd;

    assign unused_cmd = ^cmd_data;

    // two synchroniser flops, then one more for edge detection
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sd_q <= '0;
        else        sd_q <= {sd_q[1:0], sdata_in};
    end

    assign rise     = sd_q[1] & ~sd_q[2];
    assign pd_write = cmd_valid && !cmd_rd && (cmd_addr == PD_ADDR) && cmd_data[PD_BIT];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= LINK_ACTIVE;
        else        state <= state_n;
    end

    always_comb begin
        state_n = state;
        unique case (state)
            LINK_ACTIVE: if (pd_write && !link_reset_req) state_n = LINK_DOWN;
            LINK_DOWN:   if (link_reset_req)              state_n = LINK_ACTIVE;
            default:     state_n = LINK_ACTIVE;
        endcase
    end

    always_comb begin
        link_down = (state == LINK_DOWN);
        wake_evt  = link_down && rise;
    end

    assert_pd_enter_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == LINK_ACTIVE && pd_write && !link_reset_req) |=> link_down);

    assert_pd_exit_R6: assert property (@(posedge clk) disable iff (!rst_n)
        link_reset_req |=> !link_down);

endmodule

// File: rtl/codec_irq_ctrl.sv
module codec_irq_ctrl
    import cil_pkg::*;
#(
    parameter int         NUM_RX_CH = 2,
    parameter int         TOC_W     = 4,
    parameter int         S12_W     = 20,
    parameter int         DATA_W    = 32,
    parameter logic [6:0] PD_ADDR   = 7'h26,
    parameter int         PD_BIT    = 12
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 frame_strobe,
    input  logic                 tag_valid,
    input  logic                 tag_ready_bit,
    input  logic                 s12_valid,
    input  logic [S12_W-1:0]     s12_word,
    input  logic                 cmd_valid,
    input  logic                 cmd_rd,
    input  logic [6:0]           cmd_addr,
    input  logic [15:0]          cmd_data,
    input  logic                 link_reset_req,
    input  logic [NUM_RX_CH-1:0] rx_push,
    input  logic [NUM_RX_CH-1:0] rx_empty,
    input  logic                 tx_empty,
    input  logic                 shifter_idle,
    input  logic                 sdata_in,
    input  logic                 wr_en,
    input  logic [2:0]           wr_addr,
    input  logic [DATA_W-1:0]    wr_data,
    input  logic                 rd_en,
    input  logic [2:0]           rd_addr,
    output logic [DATA_W-1:0]    rd_data,
    output logic                 irq_out
);

    localparam int ST_W   = NUM_RX_CH + 4;
    localparam int B_TXC  = NUM_RX_CH;
    localparam int B_CRDY = NUM_RX_CH + 1;
    localparam int B_WAKE = NUM_RX_CH + 2;
    localparam int B_GPIO = NUM_RX_CH + 3;
    localparam int TOC_TW = NUM_RX_CH * TOC_W;
    localparam int NSTICK = 3;

    logic [ST_W-1:0]      mask_q, raw, masked;
    logic [TOC_TW-1:0]    toc_q;
    logic [S12_W-1:0]     s12_q;
    logic [NUM_RX_CH-1:0] rto;
    logic                 txc_q;
    logic                 link_down, wake_evt;
    logic                 eoi_wr, s12_rd;
    logic [NSTICK-1:0]    st_set, st_clr, st_q;
    logic                 unused_wr;

    assign unused_wr = ^wr_data;
    assign eoi_wr    = wr_en && (wr_addr == RA_EOI);
    assign s12_rd    = rd_en && (rd_addr == RA_S12);

    for (genvar k = 0; k < NUM_RX_CH; k++) begin : g_rx
        cil_rx_timeout #(.TOC_W(TOC_W)) u_to (
            .clk          (clk),
            .rst_n        (rst_n),
            .frame_strobe (frame_strobe),
            .rx_push      (rx_push[k]),
            .rx_empty     (rx_empty[k]),
            .toc          (toc_q[k*TOC_W +: TOC_W]),
            .timeout      (rto[k])
        );
    end

    cil_link_power #(.PD_ADDR(PD_ADDR), .PD_BIT(PD_BIT)) u_pwr (
        .clk            (clk),
        .rst_n          (rst_n),
        .cmd_valid      (cmd_valid),
        .cmd_rd         (cmd_rd),
        .cmd_addr       (cmd_addr),
        .cmd_data       (cmd_data),
        .link_reset_req (link_reset_req),
        .sdata_in       (sdata_in),
        .link_down      (link_down),
        .wake_evt       (wake_evt)
    );

    // sticky sources: 0 codec ready, 1 wake, 2 gpio change
    assign st_set = {s12_valid && s12_word[0], wake_evt, tag_valid && tag_ready_bit};
    assign st_clr = {s12_rd, eoi_wr && wr_data[B_WAKE], eoi_wr && wr_data[B_CRDY]};

    for (genvar k = 0; k < NSTICK; k++) begin : g_st
        cil_sticky u_st (
            .clk   (clk),
            .rst_n (rst_n),
            .set   (st_set[k]),
            .clr   (st_clr[k]),
            .q     (st_q[k])
        );
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mask_q  <= '0;
            toc_q   <= '0;
            s12_q   <= '0;
            txc_q   <= 1'b0;
            irq_out <= 1'b0;
        end else begin
            if (wr_en && wr_addr == RA_MASK) mask_q <= wr_data[ST_W-1:0];
            if (wr_en && wr_addr == RA_TOC)  toc_q  <= wr_data[TOC_TW-1:0];
            if (s12_valid)                   s12_q  <= s12_word;
            txc_q   <= tx_empty && shifter_idle;
            irq_out <= |masked;
        end
    end

    assign raw    = {st_q[2], st_q[1], st_q[0], txc_q, rto};
    assign masked = raw & mask_q;

    always_comb begin
        rd_data = '0;
        case (rd_addr)
            RA_MASK: rd_data = DATA_W'(mask_q);
            RA_RAW:  rd_data = DATA_W'(raw);
            RA_MSKD: rd_data = DATA_W'(masked);
            RA_TOC:  rd_data = DATA_W'(toc_q);
            RA_S12:  rd_data = DATA_W'(s12_q);
            default: rd_data = '0;
        endcase
    end

    assert_txc_follow_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_empty && shifter_idle) |=> raw[B_TXC]);

    assert_crdy_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (raw[B_CRDY] && !(eoi_wr && wr_data[B_CRDY])) |=> raw[B_CRDY]);

    assert_wake_needs_down_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(raw[B_WAKE]) |-> $past(link_down));

    assert_gpio_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (raw[B_GPIO] && !s12_rd) |=> raw[B_GPIO]);

    assert_irq_high_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (|masked) |=> irq_out);

    assert_irq_low_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !(|masked) |=> !irq_out);

endmodule

// File: tb/sim_codec_irq_ctrl.sv
`timescale 1ns/1ps
module sim_codec_irq_ctrl;

    localparam int N  = 2;
    localparam int TW = 3;
    localparam int SW = 20;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          frame_strobe = 0, tag_valid = 0, tag_ready_bit = 0;
    logic          s12_valid = 0;
    logic [SW-1:0] s12_word = '0;
    logic          cmd_valid = 0, cmd_rd = 0;
    logic [6:0]    cmd_addr = '0;
    logic [15:0]   cmd_data = '0;
    logic          link_reset_req = 0;
    logic [N-1:0]  rx_push = '0, rx_empty = '1;
    logic          tx_empty = 0, shifter_idle = 0, sdata_in = 0;
    logic          wr_en = 0, rd_en = 0;
    logic [2:0]    wr_addr = '0, rd_addr = '0;
    logic [31:0]   wr_data = '0;
    logic [31:0]   rd_data;
    logic          irq_out;

    codec_irq_ctrl #(.NUM_RX_CH(N), .TOC_W(TW), .S12_W(SW)) u0 (
        .clk(clk), .rst_n(rst_n), .frame_strobe(frame_strobe),
        .tag_valid(tag_valid), .tag_ready_bit(tag_ready_bit),
        .s12_valid(s12_valid), .s12_word(s12_word),
        .cmd_valid(cmd_valid), .cmd_rd(cmd_rd), .cmd_addr(cmd_addr), .cmd_data(cmd_data),
        .link_reset_req(link_reset_req), .rx_push(rx_push), .rx_empty(rx_empty),
        .tx_empty(tx_empty), .shifter_idle(shifter_idle), .sdata_in(sdata_in),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data), .irq_out(irq_out)
    );

    always #2 clk = ~clk;

    typedef struct {
        bit          is_irq;
        logic [31:0] exp;
        string       req;
    } item_t;

    item_t sb[$];
    int    total = 0;
    int    bad = 0;
    bit    done = 0;
    logic  probe_rd = 0, probe_irq = 0;

    // monitor: pops the expected item and compares mid-cycle
    always @(negedge clk) begin
        if (probe_rd || probe_irq) begin
            item_t it;
            logic [31:0] got;
            total++;
            if (sb.size() == 0) begin
                bad++;
                $display("FAIL scoreboard empty got=%h exp=item", rd_data);
            end else begin
                it  = sb.pop_front();
                got = it.is_irq ? {31'd0, irq_out} : rd_data;
                if (got !== it.exp) begin
                    bad++;
                    $display("FAIL %s got=%h exp=%h", it.req, got, it.exp);
                end
            end
        end
    end

    task automatic tick;
        @(posedge clk);
        #1;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) tick();
    endtask

    task automatic rd_chk(input logic [2:0] a, input logic [31:0] e, input string r);
        rd_en = 1; rd_addr = a; probe_rd = 1;
        sb.push_back('{is_irq: 1'b0, exp: e, req: r});
        tick();
        rd_en = 0; probe_rd = 0;
    endtask

    task automatic irq_chk(input bit e, input string r);
        probe_irq = 1;
        sb.push_back('{is_irq: 1'b1, exp: {31'd0, e}, req: r});
        tick();
        probe_irq = 0;
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        wr_en = 1; wr_addr = a; wr_data = d;
        tick();
        wr_en = 0; wr_data = '0;
    endtask

    task automatic strobe(input int n);
        for (int i = 0; i < n; i++) begin
            frame_strobe = 1; tick();
            frame_strobe = 0; tick();
        end
    endtask

    task automatic push(input int ch);
        rx_push[ch] = 1; tick(); rx_push[ch] = 0;
    endtask

    task automatic send_cmd(input bit rd, input logic [15:0] d);
        cmd_valid = 1; cmd_rd = rd; cmd_addr = 7'h26; cmd_data = d;
        tick();
        cmd_valid = 0; cmd_rd = 0; cmd_data = '0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog got=hung exp=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        ticks(3);
        rst_n = 1;
        tick();
        // reset state
        rd_chk(3'd2, 32'h0, "R9 raw after reset");
        rd_chk(3'd0, 32'h0, "R9 mask after reset");
        irq_chk(0, "R10 irq after reset");

        // transmit complete
        tx_empty = 1; shifter_idle = 0; tick();
        rd_chk(3'd2, 32'h0, "R4 fifo empty shifter busy");
        shifter_idle = 1; tick();
        rd_chk(3'd2, 32'h4, "R4 both idle");
        tx_empty = 0; tick();
        rd_chk(3'd2, 32'h0, "R4 fifo refilled");
        shifter_idle = 0;

        // codec ready
        tag_valid = 1; tag_ready_bit = 1; tick(); tag_valid = 0; tag_ready_bit = 0;
        rd_chk(3'd2, 32'h8, "R5 ready set");
        wr(3'd1, 32'h0);
        rd_chk(3'd2, 32'h8, "R5 eoi zero no effect");
        wr(3'd1, 32'h8);
        rd_chk(3'd2, 32'h0, "R5 eoi clears");
        tag_valid = 1; tag_ready_bit = 0; tick(); tag_valid = 0;
        rd_chk(3'd2, 32'h0, "R5 tag without flag");

        // mask and interrupt latency
        tag_valid = 1; tag_ready_bit = 1; tick(); tag_valid = 0; tag_ready_bit = 0;
        irq_chk(0, "R10 masked off");
        wr(3'd0, 32'h8);
        irq_chk(0, "R10 one cycle latency");
        irq_chk(1, "R10 irq rises");
        wr(3'd1, 32'h8);
        irq_chk(1, "R10 fall latency");
        irq_chk(0, "R10 irq falls");

        // receive timeout channel 0 (T=3), channel 1 disabled
        wr(3'd4, 32'd3);
        rd_chk(3'd4, 32'd3, "R9 toc readback");
        rx_empty[0] = 0; push(0);
        strobe(2);
        rd_chk(3'd2, 32'h0, "R1 before expiry");
        push(0);
        strobe(2);
        rd_chk(3'd2, 32'h0, "R1 reload by push");
        strobe(1);
        rd_chk(3'd2, 32'h1, "R1 expiry ch0");
        rx_empty[0] = 1; tick();
        rd_chk(3'd2, 32'h0, "R2 drain clears");

        rx_empty[1] = 0; push(1);
        strobe(10);
        rd_chk(3'd2, 32'h0, "R3 zero count ch1");
        wr(3'd4, 32'd43);
        push(1);
        strobe(4);
        rd_chk(3'd2, 32'h0, "R1 ch1 before expiry");
        strobe(1);
        rd_chk(3'd2, 32'h2, "R1 expiry ch1 only");
        rx_empty[1] = 1; tick();
        rd_chk(3'd2, 32'h0, "R2 drain ch1");

        rx_empty[0] = 0; push(0);
        strobe(2);
        wr(3'd4, 32'd40);
        strobe(5);
        rd_chk(3'd2, 32'h0, "R3 disabled mid count");
        rx_empty[0] = 1; tick();

        // wake-up
        sdata_in = 1; ticks(5);
        rd_chk(3'd2, 32'h0, "R6 edge ignored while active");
        sdata_in = 0; ticks(4);
        send_cmd(1, 16'h1000);
        sdata_in = 1; ticks(5);
        rd_chk(3'd2, 32'h0, "R6 read command no power down");
        sdata_in = 0; ticks(4);
        send_cmd(0, 16'h0800);
        sdata_in = 1; ticks(5);
        rd_chk(3'd2, 32'h0, "R6 write without pd bit");
        sdata_in = 0; ticks(4);
        send_cmd(0, 16'h1000);
        sdata_in = 1; ticks(2);
        rd_chk(3'd2, 32'h0, "R7 not yet after two edges");
        rd_chk(3'd2, 32'h10, "R7 wake on third edge");
        wr(3'd1, 32'h10);
        rd_chk(3'd2, 32'h0, "R7 eoi clears wake");
        sdata_in = 0; ticks(4);
        link_reset_req = 1; tick(); link_reset_req = 0;
        sdata_in = 1; ticks(5);
        rd_chk(3'd2, 32'h0, "R6 link reset leaves down state");
        sdata_in = 0;

        // gpio change
        s12_valid = 1; s12_word = 20'hABCD1; tick(); s12_valid = 0;
        rd_chk(3'd2, 32'h20, "R8 gpio set");
        rd_chk(3'd5, 32'hABCD1, "R8 slot12 word");
        rd_chk(3'd2, 32'h0, "R8 read clears");
        s12_valid = 1; s12_word = 20'h12340; tick(); s12_valid = 0;
        rd_chk(3'd2, 32'h0, "R8 bit0 low no set");
        rd_chk(3'd5, 32'h12340, "R8 latest word latched");

        // masked view with several sources
        tag_valid = 1; tag_ready_bit = 1; tick(); tag_valid = 0; tag_ready_bit = 0;
        s12_valid = 1; s12_word = 20'h00001; tick(); s12_valid = 0;
        rd_chk(3'd2, 32'h28, "R9 raw two sources");
        rd_chk(3'd3, 32'h08, "R9 masked view");
        irq_chk(1, "R10 irq with masked source");
        wr(3'd0, 32'h20);
        rd_chk(3'd3, 32'h20, "R9 masked after remask");
        rd_chk(3'd0, 32'h20, "R9 mask readback");

        tick();
        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule